// File: doc/BRIEF.md
# Microcoded Sequencer with Reconfiguration Watchdog

The block is a small microcoded controller that runs a fixed program stored in an internal byte-wide ROM of 544 locations. Every instruction takes two bytes: an opcode, then an immediate. The controller fetches the two bytes into two instruction registers on consecutive clocks, advancing a 10-bit program counter once per byte. On the third clock it decodes and executes the instruction. The instruction set is small: a timed no-op that freezes the program counter for a programmable number of clocks, an unconditional jump, a one-clock output pulse carrying the immediate byte, and a load of a held flag byte.

An external reconfiguration timeout input overrides everything else. It aborts the instruction in progress, or a running wait, sends the program counter back to address zero and sets a sticky status bit. The status bit stays set until a read-and-clear strobe removes it. A host reads the status byte and applies that strobe afterwards.

Top module: `useq_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the program counter, both instruction registers, the wait counter, `strobe_o`, `data_o`, `flags_o` and `status_o`. After reset, fetching starts at address 0.
- R2: An instruction uses three clocks. On the first, the byte at the program counter goes to the opcode register. On the second, the next byte goes to the immediate register. The counter advances by one on each of these two clocks. On the third clock the instruction executes, and the counter holds unless the instruction is a jump. ROM addresses at or above 544 read as 0xFF.
- R3: Opcode 0x00 is a timed no-op. With immediate N > 0, its execute clock is followed by N×PRESCALE wait clocks (PRESCALE defaults to 4). `status_o[6]` is high during these clocks and the program counter holds its value. With N = 0 there are no wait clocks.
- R4: Opcodes 0x10 to 0x13 jump. The program counter is loaded with {opcode[1:0], immediate}, and the next opcode is fetched from that address.
- R5: Opcode 0x20 makes `strobe_o` high for exactly one clock, the clock after execute, with `data_o` equal to the immediate. Whenever `strobe_o` is low, `data_o` is 0x00.
- R6: Opcode 0x30 loads `flags_o` with the immediate. `flags_o` then holds that value until another 0x30 or a reset.
- R7: Any other opcode executes in one clock and has no effect on `strobe_o`, `data_o` or `flags_o`.
- R8: When `recon_i` is high at a clock edge, the program counter becomes 0, any instruction or wait in progress is dropped, the next fetch is an opcode fetch from address 0, and `status_o[7]` becomes 1.
- R9: `status_o[7]` stays 1 until a clock edge at which `stat_clr` is high and `recon_i` is low. If both are high at the same edge, the bit stays 1. `status_o[5:0]` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| recon_i | input | 1 | Reconfiguration timeout, forces restart at address 0 |
| stat_clr | input | 1 | Read-and-clear strobe for the sticky status bit |
| strobe_o | output | 1 | One-clock output pulse from the pulse opcode |
| data_o | output | 8 | Pulse value, valid while strobe_o is high |
| flags_o | output | 8 | Flag byte loaded by the flag opcode |
| status_o | output | 8 | Bit 7 sticky timeout flag, bit 6 wait in progress |
| pc_o | output | 10 | Current program counter |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is the timeout and the status read-and-clear strobe. The bench raises both on one edge and then expects bit 7 to remain set. A clear applied alone on a later edge must drop the bit. The second pair is the timeout and the sequencer's own progress: timeouts are fired at offsets that land on opcode fetches, immediate fetches, execute clocks and wait clocks. A behavioural model tracks the expected program counter, outputs and status on every clock, so an abort that leaves a wait running or lets a jump or pulse complete shows up as a mismatch.

// File: rtl/useq_core.sv
module useq_core #(
  parameter int         ROM_DEPTH = 544,
  parameter int         PC_W      = 10,
  parameter int         PRESCALE  = 4,
  parameter logic [7:0] FILL      = 8'hFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            recon_i,
  input  logic            stat_clr,
  output logic            strobe_o,
  output logic [7:0]      data_o,
  output logic [7:0]      flags_o,
  output logic [7:0]      status_o,
  output logic [PC_W-1:0] pc_o
);
  localparam int CNT_W = $clog2(255 * PRESCALE + 1);

  typedef enum logic [1:0] {S_OP, S_IMM, S_EXE, S_LOOP} stage_t;

  function automatic logic [7:0] prog_byte(input int a);
    case (a)
      0:   return 8'h20;  1:   return 8'hA5;
      2:   return 8'h30;  3:   return 8'h3C;
      4:   return 8'h00;  5:   return 8'h03;
      6:   return 8'h00;  7:   return 8'h00;
      8:   return 8'h7E;  9:   return 8'h11;
      10:  return 8'h12;  11:  return 8'h00;
      512: return 8'h20;  513: return 8'h5A;
      514: return 8'h30;  515: return 8'hC3;
      516: return 8'h10;  517: return 8'h00;
      default: return FILL;
    endcase
  endfunction

  logic [7:0] rom [ROM_DEPTH];
  for (genvar a = 0; a < ROM_DEPTH; a++) begin : g_rom
    assign rom[a] = prog_byte(a);
  end

  stage_t            stage;
  logic [PC_W-1:0]   pc;
  logic [7:0]        op_q, imm_q;
  logic [CNT_W-1:0]  cnt;
  logic              recon_q;

  wire [7:0]       fetch_byte = (int'(pc) < ROM_DEPTH) ? rom[pc] : FILL;
  wire             is_nop     = op_q == 8'h00;
  wire             is_jmp     = op_q[7:2] == 6'b000100;
  wire             is_pulse   = op_q == 8'h20;
  wire             is_flag    = op_q == 8'h30;
  wire [PC_W-1:0]  jmp_tgt    = PC_W'({op_q[1:0], imm_q});
  wire [CNT_W-1:0] loop_len   = CNT_W'(int'(imm_q) * PRESCALE);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage    <= S_OP;
      pc       <= '0;
      op_q     <= '0;
      imm_q    <= '0;
      cnt      <= '0;
      recon_q  <= 1'b0;
      strobe_o <= 1'b0;
      data_o   <= '0;
      flags_o  <= '0;
    end else begin
      strobe_o <= 1'b0;
      data_o   <= '0;
      recon_q  <= recon_i | (recon_q & ~stat_clr);
      if (recon_i) begin
        pc    <= '0;
        stage <= S_OP;
        cnt   <= '0;
      end else begin
        case (stage)
          S_OP: begin
            op_q  <= fetch_byte;
            pc    <= pc + PC_W'(1);
            stage <= S_IMM;
          end
          S_IMM: begin
            imm_q <= fetch_byte;
            pc    <= pc + PC_W'(1);
            stage <= S_EXE;
          end
          S_EXE: begin
            stage <= S_OP;
            if (is_jmp) pc <= jmp_tgt;
            if (is_pulse) begin
              strobe_o <= 1'b1;
              data_o   <= imm_q;
            end
            if (is_flag) flags_o <= imm_q;
            if (is_nop && imm_q != 8'h00) begin
              cnt   <= loop_len;
              stage <= S_LOOP;
            end
          end
          default: begin
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) stage <= S_OP;
          end
        endcase
      end
    end
  end

  assign pc_o     = pc;
  assign status_o = {recon_q, stage == S_LOOP, 6'b000000};
endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk #(
  parameter int PC_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            recon_i,
  input logic            stat_clr,
  input logic            strobe_o,
  input logic [7:0]      data_o,
  input logic [7:0]      status_o,
  input logic [PC_W-1:0] pc_o
);
  AST_LOOP_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (status_o[6] && !recon_i) |=> $stable(pc_o));                        // R3
  AST_RECON_RESTART: assert property (@(posedge clk) disable iff (rst)
    recon_i |=> (pc_o == '0 && status_o[7]));                            // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);                                             // R5
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
    !strobe_o |-> data_o == 8'h00);                                      // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status_o[7] && !stat_clr) |=> status_o[7]);                         // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !recon_i) |=> !status_o[7]);                            // R9
endmodule

bind useq_core useq_core_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .recon_i(recon_i), .stat_clr(stat_clr),
  .strobe_o(strobe_o), .data_o(data_o), .status_o(status_o), .pc_o(pc_o)
);

// File: tb/sim_useq_core.sv
module sim_useq_core;
  localparam int PRE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic recon_i = 1'b0;
  logic stat_clr = 1'b0;
  logic       strobe_o;
  logic [7:0] data_o, flags_o, status_o;
  logic [9:0] pc_o;

  always #5 clk = ~clk;

  useq_core u0 (.clk(clk), .rst(rst), .recon_i(recon_i), .stat_clr(stat_clr),
                .strobe_o(strobe_o), .data_o(data_o), .flags_o(flags_o),
                .status_o(status_o), .pc_o(pc_o));

  int n_chk = 0, n_fail = 0;
  int m_pc, m_stage, m_op, m_imm, m_wait, m_flag, m_strobe, m_data, m_flags;
  bit started = 0, saw_jump = 0, saw_a5 = 0, recon_in_wait = 0;

  function automatic int prog(int a);
    case (a)
      0: return 'h20;   1: return 'hA5;   2: return 'h30;   3: return 'h3C;
      4: return 'h00;   5: return 'h03;   6: return 'h00;   7: return 'h00;
      8: return 'h7E;   9: return 'h11;   10: return 'h12;  11: return 'h00;
      512: return 'h20; 513: return 'h5A; 514: return 'h30; 515: return 'hC3;
      516: return 'h10; 517: return 'h00;
      default: return 'hFF;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, stage: 0 opcode fetch, 1 immediate fetch, 2 execute, 3 waiting
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_pc = 0; m_stage = 0; m_op = 0; m_imm = 0; m_wait = 0;
      m_flag = 0; m_strobe = 0; m_data = 0; m_flags = 0;
    end else begin
      m_strobe = 0; m_data = 0;
      if (recon_i) begin
        if (m_stage == 3) recon_in_wait = 1;
        m_pc = 0; m_stage = 0; m_wait = 0; m_flag = 1;
      end else begin
        if (stat_clr) m_flag = 0;
        if (m_stage == 0) begin
          m_op = prog(m_pc); m_pc = (m_pc + 1) % 1024; m_stage = 1;
        end else if (m_stage == 1) begin
          m_imm = prog(m_pc); m_pc = (m_pc + 1) % 1024; m_stage = 2;
        end else if (m_stage == 2) begin
          m_stage = 0;
          if (m_op >= 'h10 && m_op <= 'h13) m_pc = (m_op % 4) * 256 + m_imm;
          else if (m_op == 'h20) begin m_strobe = 1; m_data = m_imm; end
          else if (m_op == 'h30) m_flags = m_imm;
          else if (m_op == 0 && m_imm != 0) begin m_wait = m_imm * PRE; m_stage = 3; end
        end else begin
          m_wait--;
          if (m_wait == 0) m_stage = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check("R2 R3 R4 R8 pc", int'(pc_o), m_pc);
      check("R5 strobe", int'(strobe_o), m_strobe);
      check("R5 data", int'(data_o), m_data);
      check("R6 R7 flags", int'(flags_o), m_flags);
      check("R8 R9 status7", int'(status_o[7]), m_flag);
      check("R3 status6", int'(status_o[6]), (m_stage == 3) ? 1 : 0);
      check("R9 status_low", int'(status_o[5:0]), 0);
      if (pc_o == 10'd512) saw_jump = 1;
      if (strobe_o && data_o == 8'hA5) saw_a5 = 1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 pc", int'(pc_o), 0);
    check("R1 outputs", int'({strobe_o, data_o, flags_o}), 0);
    check("R1 status", int'(status_o), 0);
    rst = 1'b0;
    repeat (150) @(negedge clk);
    check("R4 jump reached 512", int'(saw_jump), 1);
    check("R5 pulse A5 seen", int'(saw_a5), 1);
    for (int k = 0; k < 14; k++) begin
      repeat (3 + (k * 11) % 37) @(negedge clk);
      recon_i = 1'b1;
      @(negedge clk);
      recon_i = 1'b0;
      repeat (k % 5) @(negedge clk);
      if (k % 2 == 1) begin
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
      end
    end
    check("R8 timeout hit a wait", int'(recon_in_wait), 1);
    // R9 coincident timeout and clear
    recon_i = 1'b1; stat_clr = 1'b1;
    @(negedge clk);
    recon_i = 1'b0; stat_clr = 1'b0;
    check("R9 timeout wins over clear", int'(status_o[7]), 1);
    repeat (5) @(negedge clk);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    check("R9 clear alone", int'(status_o[7]), 0);
    repeat (23) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run pc", int'(pc_o), 0);
    check("R1 mid-run flags", int'(flags_o), 0);
    rst = 1'b0;
    repeat (80) @(negedge clk);
    summary();
  end
endmodule